// File: doc/BRIEF.md
# Timer Output Compare Unit

This block holds an up-counting timer value and a compare value, and watches each timer tick for the moment the two are equal. When a genuine match occurs, it sets a sticky match flag. In the same cycle it updates an internal waveform bit. A 2-bit action field decides whether that bit is left alone, toggled, cleared or set. Software drives the block through a small register write port. The port can load the counter, the compare value and the control field, and it can clear the flag.

Two behaviours make the block safe to program. First, every CPU write to the counter arms a one-tick blanking window, so the counter can be preloaded with the compare value without a spurious flag. This works whether the timer is running or halted. Second, a force strobe in the control register applies the selected action to the waveform bit immediately. The force leaves the flag and the counter untouched, which lets software put the output in a known state before enabling the timer. The force is ignored while the control write also selects PWM operation.

Top module: `occ_unit`

## Requirements
- R1: While reset is low, the count reads 0 and both the match flag and the waveform bit read 0.
- R2: Each cycle with `tick_i` high and no counter write, the count rises by one, wrapping from all ones to 0. Without a tick or a counter write, the count holds.
- R3: A genuine match needs three conditions: `tick_i` is high, the count equals the compare value, and no blanking window is armed. It sets the flag at that clock edge. The flag stays high until a write to address 3 with data bit 0 set. A write of 0 there has no effect. A match in the same cycle as a clear leaves the flag set.
- R4: On a genuine match, the 2-bit action field (control bits 1:0) acts on the waveform bit. 00 leaves it unchanged, 01 toggles it, 10 clears it and 11 sets it.
- R5: A control write (address 2) with bit 2 set and bit 3 clear applies the action to the waveform bit at once. The flag and the count do not change.
- R6: A counter write (address 0) arms a blanking window. The window suppresses any match at the first later tick, however many tickless cycles pass before it. Later ticks match normally.
- R7: When a counter write and a tick share a cycle, the written value is loaded without increment. No match occurs in that cycle, and the blanking window is armed.
- R8: The action field is not buffered. A new value written to address 2 governs the very next match or force, including a force carried in the same write.
- R9: A control write with bit 3 set (PWM operation) ignores the force bit. Changing bit 3 never alters the waveform bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Timer clock enable; one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register address: 0 counter, 1 compare, 2 control, 3 flag clear |
| wr_data_i | input | CNT_W | Write data |
| count_o | output | CNT_W | Current counter value |
| cmp_flag_o | output | 1 | Sticky compare match flag |
| wave_o | output | 1 | Internal waveform output bit |

## Verification
Three blanking cases get dedicated scenarios. One preloads the counter with the compare value and then idles before the first tick; a design that timed the window in cycles rather than ticks would raise the flag. Another checks that the window expires after one tick; a window that stuck would miss the following real match. A third collides a counter write with a tick; a design that let the tick win would increment past the written value. Force strobes are checked for untouched flag and count, and each action code is applied from a known waveform state. Without that, a hold-versus-clear confusion could go unseen. The action field is changed between the last tick and the matching tick, which catches a design that latched the field early. A clear that collides with a match is also checked; a design that lets the clear win would lose the event.

// File: rtl/occ_pkg.sv
package occ_pkg;

   typedef enum logic [1:0] {
      OCM_HOLD   = 2'b00,
      OCM_TOGGLE = 2'b01,
      OCM_CLEAR  = 2'b10,
      OCM_SET    = 2'b11
   } ocm_act_e;

   localparam int REG_COUNT = 0;
   localparam int REG_CMP   = 1;
   localparam int REG_CTRL  = 2;
   localparam int REG_FLAG  = 3;

   localparam int CTRL_FORCE_BIT = 2;
   localparam int CTRL_PWM_BIT   = 3;
   localparam int CTRL_MIN_W     = 4;

   function automatic logic apply_act(input ocm_act_e act, input logic cur);
      case (act)
         OCM_TOGGLE: apply_act = ~cur;
         OCM_CLEAR:  apply_act = 1'b0;
         OCM_SET:    apply_act = 1'b1;
         default:    apply_act = cur;
      endcase
   endfunction

endpackage

// File: rtl/occ_counter.sv
module occ_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             hit_ok_o
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         blank_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= load_val_i;
         blank_q <= 1'b1;
      end else if (tick_i) begin
         cnt_q   <= cnt_q + STEP;
         blank_q <= 1'b0;
      end
   end

   assign cnt_o    = cnt_q;
   assign hit_ok_o = tick_i && !load_i && !blank_q;

endmodule

// File: rtl/occ_match.sv
module occ_match #(
   parameter int CNT_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmp_we_i,
   input  logic [CNT_W-1:0] cmp_d_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             hit_ok_i,
   input  logic             clr_i,
   output logic             match_o,
   output logic             flag_o
);
   logic [CNT_W-1:0] cmp_q;
   logic             flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q <= '0;
      else if (cmp_we_i) cmp_q <= cmp_d_i;
   end

   assign match_o = hit_ok_i && (cnt_i == cmp_q);

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flag_q <= 1'b0;
            else if (match_o) flag_q <= 1'b1;
            else if (clr_i)   flag_q <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       flag_q <= 1'b0;
            else if (clr_i)   flag_q <= 1'b0;
            else if (match_o) flag_q <= 1'b1;
         end
      end
   endgenerate

   assign flag_o = flag_q;

endmodule

// File: rtl/occ_wave.sv
module occ_wave
   import occ_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  ocm_act_e act_i,
   input  logic     match_i,
   input  logic     force_i,
   output logic     wave_o
);
   logic wave_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  wave_q <= 1'b0;
      else if (match_i || force_i) wave_q <= apply_act(act_i, wave_q);
   end

   assign wave_o = wave_q;

endmodule

// File: rtl/occ_unit.sv
module occ_unit
   import occ_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int ADDR_W   = 2,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [CNT_W-1:0]  wr_data_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              cmp_flag_o,
   output logic              wave_o
);
   generate
      if (CNT_W < CTRL_MIN_W || CNT_W > 32) begin : g_bad_width
         $error("occ_unit: CNT_W must lie in 4..32");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("occ_unit: ADDR_W must be at least 2");
      end
   endgenerate

   logic     wr_cnt, wr_cmp, wr_ctrl, wr_clr;
   logic     hit_ok, match, force_req;
   ocm_act_e act_q, act_eff;

   assign wr_cnt  = wr_en_i && (wr_addr_i == ADDR_W'(REG_COUNT));
   assign wr_cmp  = wr_en_i && (wr_addr_i == ADDR_W'(REG_CMP));
   assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_W'(REG_CTRL));
   assign wr_clr  = wr_en_i && (wr_addr_i == ADDR_W'(REG_FLAG)) && wr_data_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       act_q <= OCM_HOLD;
      else if (wr_ctrl) act_q <= ocm_act_e'(wr_data_i[1:0]);
   end

   assign act_eff   = wr_ctrl ? ocm_act_e'(wr_data_i[1:0]) : act_q;
   assign force_req = wr_ctrl && wr_data_i[CTRL_FORCE_BIT] && !wr_data_i[CTRL_PWM_BIT];

   occ_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .load_i     (wr_cnt),
      .load_val_i (wr_data_i),
      .cnt_o      (count_o),
      .hit_ok_o   (hit_ok)
   );

   occ_match #(.CNT_W(CNT_W), .SET_WINS(SET_WINS)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_we_i (wr_cmp),
      .cmp_d_i  (wr_data_i),
      .cnt_i    (count_o),
      .hit_ok_i (hit_ok),
      .clr_i    (wr_clr),
      .match_o  (match),
      .flag_o   (cmp_flag_o)
   );

   occ_wave u_wave (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_i   (act_eff),
      .match_i (match),
      .force_i (force_req),
      .wave_o  (wave_o)
   );

endmodule

// File: rtl/occ_unit_chk.sv
module occ_unit_chk #(
   parameter int CNT_W  = 8,
   parameter int ADDR_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [CNT_W-1:0]  wr_data_i,
   input logic [CNT_W-1:0]  count_o,
   input logic              cmp_flag_o,
   input logic              wave_o
);
   logic c_cnt, c_ctrl, c_clr, c_force, pend_q;

   assign c_cnt   = wr_en_i && (wr_addr_i == ADDR_W'(0));
   assign c_ctrl  = wr_en_i && (wr_addr_i == ADDR_W'(2));
   assign c_clr   = wr_en_i && (wr_addr_i == ADDR_W'(3)) && wr_data_i[0];
   assign c_force = c_ctrl && wr_data_i[2] && !wr_data_i[3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q <= 1'b0;
      else if (c_cnt)  pend_q <= 1'b1;
      else if (tick_i) pend_q <= 1'b0;
   end

   // R1
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> (count_o == '0 && !cmp_flag_o && !wave_o));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i && !c_cnt |=> (count_o - $past(count_o)) == CNT_W'(1));

   // R2
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i && !c_cnt |=> $stable(count_o));

   // R3
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_flag_o && !c_clr |=> cmp_flag_o);

   // R5
   force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_force && !tick_i && !cmp_flag_o |=> !cmp_flag_o);

   // R5
   force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_force && wr_data_i[1:0] == 2'b11 |=> wave_o);

   // R6
   blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && tick_i && !c_cnt && !cmp_flag_o |=> !cmp_flag_o);

   // R7
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_cnt |=> count_o == $past(wr_data_i));

   // R7
   load_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_cnt && !cmp_flag_o |=> !cmp_flag_o);

   // R9
   pwm_keep_wave_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_ctrl && wr_data_i[3] && !tick_i |=> $stable(wave_o));

endmodule

bind occ_unit occ_unit_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tick_i     (tick_i),
   .wr_en_i    (wr_en_i),
   .wr_addr_i  (wr_addr_i),
   .wr_data_i  (wr_data_i),
   .count_o    (count_o),
   .cmp_flag_o (cmp_flag_o),
   .wave_o     (wave_o)
);

// File: tb/tb_occ_unit.sv
`timescale 1ns/1ps
module tb_occ_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic [1:0] wr_addr_i = '0;
   logic [7:0] wr_data_i = '0;
   logic [7:0] count_o;
   logic       cmp_flag_o, wave_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   occ_unit dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .count_o(count_o), .cmp_flag_o(cmp_flag_o), .wave_o(wave_o)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic [1:0] a, input logic [7:0] d, input logic t);
      wr_en_i = en; wr_addr_i = a; wr_data_i = d; tick_i = t;
      @(negedge clk);
      wr_en_i = 1'b0; tick_i = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      drive(1'b1, a, d, 1'b0);
   endtask

   task automatic tk();
      drive(1'b0, 2'd0, 8'd0, 1'b1);
   endtask

   task automatic t_reset();
      check("R1", "count", count_o, 0);
      check("R1", "flag", cmp_flag_o, 0);
      check("R1", "wave", wave_o, 0);
   endtask

   task automatic t_count();
      wr(2'd1, 8'h80);
      wr(2'd0, 8'hFD);
      check("R2", "loaded count", count_o, 8'hFD);
      tk(); tk(); tk();
      check("R2", "wrapped count", count_o, 0);
      drive(1'b0, 2'd0, 8'd0, 1'b0);
      drive(1'b0, 2'd0, 8'd0, 1'b0);
      check("R2", "count held", count_o, 0);
   endtask

   task automatic t_match();
      wr(2'd1, 8'd5);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'd3);
      tk(); tk();
      check("R3", "no flag before match", cmp_flag_o, 0);
      tk();
      check("R3", "flag on match", cmp_flag_o, 1);
      check("R4", "toggle 0->1", wave_o, 1);
      check("R2", "count after match", count_o, 6);
   endtask

   task automatic t_flag();
      wr(2'd3, 8'h00);
      check("R3", "zero write keeps flag", cmp_flag_o, 1);
      wr(2'd3, 8'h01);
      check("R3", "flag cleared", cmp_flag_o, 0);
      wr(2'd0, 8'd4);
      tk();
      drive(1'b1, 2'd3, 8'h01, 1'b1);
      check("R3", "match beats clear", cmp_flag_o, 1);
      check("R4", "toggle 1->0", wave_o, 0);
   endtask

   task automatic t_modes();
      wr(2'd2, 8'h03);
      wr(2'd0, 8'd4); tk(); tk();
      check("R4", "set action", wave_o, 1);
      wr(2'd2, 8'h02);
      wr(2'd0, 8'd4); tk(); tk();
      check("R4", "clear action", wave_o, 0);
      wr(2'd2, 8'h07);
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h00);
      wr(2'd0, 8'd4); tk(); tk();
      check("R4", "hold flag", cmp_flag_o, 1);
      check("R4", "hold keeps wave", wave_o, 1);
   endtask

   task automatic t_force();
      wr(2'd3, 8'h01);
      wr(2'd2, 8'h06);
      check("R5", "force clear wave", wave_o, 0);
      check("R5", "force leaves flag", cmp_flag_o, 0);
      check("R5", "force leaves count", count_o, 6);
      wr(2'd2, 8'h05);
      check("R8", "force uses same-write action", wave_o, 1);
   endtask

   task automatic t_blank_stopped();
      wr(2'd0, 8'd5);
      for (int i = 0; i < 5; i++) drive(1'b0, 2'd0, 8'd0, 1'b0);
      tk();
      check("R6", "blanked preload flag", cmp_flag_o, 0);
      check("R6", "blanked preload wave", wave_o, 1);
      check("R6", "count advanced", count_o, 6);
      wr(2'd0, 8'd4); tk(); tk();
      check("R6", "window lasts one tick", cmp_flag_o, 1);
      check("R6", "toggle after window", wave_o, 0);
   endtask

   task automatic t_same_cycle();
      wr(2'd3, 8'h01);
      drive(1'b1, 2'd0, 8'd5, 1'b1);
      check("R7", "written value wins", count_o, 5);
      check("R7", "no match on load", cmp_flag_o, 0);
      tk();
      check("R7", "window armed", cmp_flag_o, 0);
      check("R7", "wave untouched", wave_o, 0);
   endtask

   task automatic t_live_mode();
      wr(2'd2, 8'h07);
      wr(2'd2, 8'h01);
      wr(2'd0, 8'd4); tk();
      wr(2'd2, 8'h03);
      tk();
      check("R8", "late action applies", wave_o, 1);
   endtask

   task automatic t_pwm();
      wr(2'd2, 8'h0E);
      check("R9", "force ignored in PWM", wave_o, 1);
      wr(2'd2, 8'h08);
      check("R9", "PWM on keeps wave", wave_o, 1);
      wr(2'd2, 8'h00);
      check("R9", "PWM off keeps wave", wave_o, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_count();
      t_match();
      t_flag();
      t_modes();
      t_force();
      t_blank_stopped();
      t_same_cycle();
      t_live_mode();
      t_pwm();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule